// File: doc/BRIEF.md
# I2C Target with Clock-Stretch Flow Control

This block is the target (slave) side of a two-wire serial bus. It watches filtered copies of the clock and data lines, recognises bus START, repeated START and STOP conditions, and compares the first byte of each transfer against a 7-bit own address and against the broadcast address 0x00 with a write direction bit. When it is addressed for a write, it accepts data bytes into a 16-entry receive queue that the host logic drains. When it is addressed for a read, it takes bytes from a valid/take transmit interface and shifts them out MSB first.

Data is never dropped or invented. If the receive queue has no room, or a read needs a byte that the transmit side has not offered yet, the block holds the clock line low until the condition clears. A configuration input can make the target refuse every received data byte. Single-cycle status pulses report a repeated START and a STOP seen while addressed, and an accepted broadcast address.

The block works as a target or not at all. The role input is captured only while the block is disabled. When the block is disabled or set to the controller role, it never drives either line.

Top module: `i2c_tgt_hold`

## Requirements
- R1: `tgt_sel` is captured only while `enable` is 0. While the block is disabled, or enabled with `tgt_sel` captured as 0, it drives neither line and acknowledges nothing. After reset both line drives are 0 and `rx_valid` is 0.
- R2: A first byte whose upper 7 bits equal `own_addr` is acknowledged: SDA is pulled low through the ninth clock. Any other address that is not an enabled broadcast gets no acknowledge.
- R3: A first byte of 0x00 is acknowledged and `gcall_pulse` is raised for one cycle, but only when `gc_ignore` is 0. This is the reset-value behaviour. With `gc_ignore` set to 1, the byte gets no acknowledge.
- R4: Data bytes of a write are acknowledged and appear on `rx_data` in arrival order, with `rx_valid` high. Asserting `rx_pop` for one cycle while `rx_valid` is high removes the head byte. The queue holds up to 16 bytes.
- R5: With `nack_data` set to 1, the address byte is still acknowledged, but each data byte gets no acknowledge and is not stored.
- R6: If the queue is full when a data byte completes, SCL is held low until a byte is popped. The byte is then stored and acknowledged.
- R7: In a read, bytes taken from `tx_data` are sent MSB first. `tx_take` pulses for one cycle for each byte consumed. If `tx_valid` is 0 when a byte is due, SCL is held low until it is 1.
- R8: A not-acknowledge from the controller after a read byte ends the read. SDA stays released, so further clocks read 1, until the next START.
- R9: A repeated START while addressed raises `restart_pulse` for one cycle. A STOP while addressed raises `stop_pulse` for one cycle. A STOP in a transfer that did not address the target raises no pulse.
- R10: Pulses on either line shorter than `FILT_LEN` (7) system-clock cycles are ignored. For example, a 3-cycle SCL spike during an address byte does not add a bit.
- R11: The target changes its SDA drive only while SCL is low. The change comes one cycle after the filtered SCL falling edge, or while the target itself holds SCL low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable |
| tgt_sel | input | 1 | Role select, 1 = target; captured while disabled |
| own_addr | input | 7 | Own 7-bit bus address |
| gc_ignore | input | 1 | 1 = do not acknowledge the broadcast address |
| nack_data | input | 1 | 1 = refuse received data bytes |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low |
| rx_valid | output | 1 | Receive queue not empty |
| rx_data | output | 8 | Head of the receive queue |
| rx_pop | input | 1 | Remove head byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_take | output | 1 | One-cycle pulse: offered byte consumed |
| restart_pulse | output | 1 | Repeated START while addressed |
| gcall_pulse | output | 1 | Broadcast address accepted |
| stop_pulse | output | 1 | STOP while addressed |

## Verification
The assertions check the following on every cycle:
- The SDA drive changes only while the filtered SCL is low.
- Each clock stretch begins only when the queue was full or no transmit byte was offered.
- Nothing is driven in the cycle after the block is disabled.
- The queue fill level stays in range.
- The status pulses last one cycle, never coincide, and a broadcast pulse never appears while broadcasts are being ignored.

Only the bench's scenarios can show the rest:
- Address matching and the broadcast response.
- The byte order through the queue and on reads.
- Refusal of data bytes.
- The release of a stretch once space or data appears.
- The end of a read on a not-acknowledge.
- The rejection of a short SCL spike.

// File: rtl/tgt_i2c_pkg.sv
package tgt_i2c_pkg;

    typedef enum logic [3:0] {
        T_IDLE,
        T_ADDR,
        T_ADR_ACK,
        T_WR_DATA,
        T_WR_ACK,
        T_RX_HOLD,
        T_RX_REL,
        T_RD_LOAD,
        T_RD_REL,
        T_RD_DATA,
        T_RD_ACK
    } tst_e;

    typedef struct packed {
        tst_e       st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic       rw;
        logic       sel;
        logic       mack;
        logic       role;
        logic       sda_low;
        logic       scl_low;
        logic       scl_p;
        logic       sda_p;
        logic       rst_p;
        logic       gc_p;
        logic       stop_p;
        logic       take;
    } core_t;

endpackage

// File: rtl/tgt_glitch_filt.sv
module tgt_glitch_filt #(
    parameter int LEN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          out;
    } flt_t;

    flt_t d, q;

    always_comb begin
        d = q;
        d.sync = {q.sync[0], din};
        if (q.sync[1] == q.out) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(LEN - 1)) begin
            d.out = q.sync[1];
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sync: 2'b11, cnt: '0, out: 1'b1};
        else        q <= d;
    end

    assign dout = q.out;
endmodule

// File: rtl/tgt_rx_fifo.sv
module tgt_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic                         valid,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_d, wp_q, rp_d, rp_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_push = push && (cnt_q != CW'(DEPTH));
        do_pop  = pop && (cnt_q != '0);
        wp_d    = do_push ? inc(wp_q) : wp_q;
        rp_d    = do_pop ? inc(rp_q) : rp_q;
        cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_d;
            rp_q  <= rp_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= wdata;
    end

    assign rdata = mem[rp_q];
    assign valid = (cnt_q != '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign count = cnt_q;
endmodule

// File: rtl/tgt_i2c_core.sv
module tgt_i2c_core
    import tgt_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       tgt_sel,
    input  logic [6:0] own_addr,
    input  logic       gc_ignore,
    input  logic       nack_data,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic       rx_full,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       push,
    output logic [7:0] push_data,
    output logic       tx_take,
    output logic       scl_low,
    output logic       sda_low,
    output logic       restart_pulse,
    output logic       gcall_pulse,
    output logic       stop_pulse
);
    core_t d, q;
    logic  scl_rise, scl_fall, start_c, stop_c, want_load;

    always_comb begin
        d         = q;
        d.rst_p   = 1'b0;
        d.gc_p    = 1'b0;
        d.stop_p  = 1'b0;
        d.take    = 1'b0;
        d.scl_p   = scl_f;
        d.sda_p   = sda_f;
        push      = 1'b0;
        want_load = 1'b0;
        scl_rise  = scl_f & ~q.scl_p;
        scl_fall  = ~scl_f & q.scl_p;
        start_c   = scl_f & q.scl_p & q.sda_p & ~sda_f;
        stop_c    = scl_f & q.scl_p & ~q.sda_p & sda_f;

        if (!enable) d.role = tgt_sel;

        if (!(enable && q.role)) begin
            d.st = T_IDLE; d.sel = 1'b0; d.cnt = '0;
            d.sda_low = 1'b0; d.scl_low = 1'b0;
        end else if (start_c) begin
            d.rst_p = q.sel; d.sel = 1'b0;
            d.st = T_ADDR; d.cnt = '0;
            d.sda_low = 1'b0; d.scl_low = 1'b0;
        end else if (stop_c) begin
            d.stop_p = q.sel; d.sel = 1'b0;
            d.st = T_IDLE; d.cnt = '0;
            d.sda_low = 1'b0; d.scl_low = 1'b0;
        end else begin
            unique case (q.st)
                T_ADDR, T_WR_DATA: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_f};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        if (q.st == T_ADDR) begin
                            d.rw = q.sh[0];
                            if (q.sh[7:1] == own_addr) begin
                                d.sel = 1'b1; d.sda_low = 1'b1; d.st = T_ADR_ACK;
                            end else if (q.sh == 8'h00 && !gc_ignore) begin
                                d.sel = 1'b1; d.sda_low = 1'b1; d.gc_p = 1'b1;
                                d.st = T_ADR_ACK;
                            end else begin
                                d.st = T_IDLE;
                            end
                        end else if (nack_data) begin
                            d.st = T_WR_ACK;
                        end else if (rx_full) begin
                            d.st = T_RX_HOLD; d.scl_low = 1'b1;
                        end else begin
                            push = 1'b1; d.sda_low = 1'b1; d.st = T_WR_ACK;
                        end
                    end
                end
                T_ADR_ACK: begin
                    if (scl_fall) begin
                        d.sda_low = 1'b0; d.cnt = '0;
                        if (q.rw) want_load = 1'b1;
                        else      d.st = T_WR_DATA;
                    end
                end
                T_WR_ACK: begin
                    if (scl_fall) begin
                        d.sda_low = 1'b0; d.cnt = '0; d.st = T_WR_DATA;
                    end
                end
                T_RX_HOLD: begin
                    if (!rx_full) begin
                        push = 1'b1; d.sda_low = 1'b1; d.st = T_RX_REL;
                    end
                end
                T_RX_REL: begin
                    d.scl_low = 1'b0; d.st = T_WR_ACK;
                end
                T_RD_LOAD: want_load = 1'b1;
                T_RD_REL: begin
                    d.scl_low = 1'b0; d.st = T_RD_DATA;
                end
                T_RD_DATA: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            d.sda_low = 1'b0; d.st = T_RD_ACK;
                        end else begin
                            d.sh      = {q.sh[6:0], 1'b0};
                            d.sda_low = ~q.sh[6];
                            d.cnt     = q.cnt + 1'b1;
                        end
                    end
                end
                T_RD_ACK: begin
                    if (scl_rise) d.mack = ~sda_f;
                    else if (scl_fall) begin
                        if (q.mack) want_load = 1'b1;
                        else        d.st = T_IDLE;
                    end
                end
                default: ;
            endcase

            if (want_load) begin
                d.cnt = '0;
                if (tx_valid) begin
                    d.sh      = tx_data;
                    d.sda_low = ~tx_data[7];
                    d.take    = 1'b1;
                    d.st      = q.scl_low ? T_RD_REL : T_RD_DATA;
                end else begin
                    d.st      = T_RD_LOAD;
                    d.scl_low = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= T_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign push_data     = q.sh;
    assign tx_take       = q.take;
    assign scl_low       = q.scl_low;
    assign sda_low       = q.sda_low;
    assign restart_pulse = q.rst_p;
    assign gcall_pulse   = q.gc_p;
    assign stop_pulse    = q.stop_p;
endmodule

// File: rtl/i2c_tgt_hold.sv
module i2c_tgt_hold #(
    parameter int FILT_LEN = 7,
    parameter int RX_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       tgt_sel,
    input  logic [6:0] own_addr,
    input  logic       gc_ignore,
    input  logic       nack_data,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    input  logic       rx_pop,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_take,
    output logic       restart_pulse,
    output logic       gcall_pulse,
    output logic       stop_pulse
);
    localparam int LINES = 2;
    localparam int CNT_W = $clog2(RX_DEPTH + 1);

    logic [LINES-1:0] raw, filt;
    logic             scl_f, sda_f;
    logic             rx_full, rx_push;
    logic [7:0]       rx_wdata;
    logic [CNT_W-1:0] rx_cnt;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_flt
        tgt_glitch_filt #(.LEN(FILT_LEN)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .dout (filt[g])
        );
    end

    assign scl_f = filt[1];
    assign sda_f = filt[0];

    tgt_i2c_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .tgt_sel      (tgt_sel),
        .own_addr     (own_addr),
        .gc_ignore    (gc_ignore),
        .nack_data    (nack_data),
        .scl_f        (scl_f),
        .sda_f        (sda_f),
        .rx_full      (rx_full),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .push         (rx_push),
        .push_data    (rx_wdata),
        .tx_take      (tx_take),
        .scl_low      (scl_drive_low),
        .sda_low      (sda_drive_low),
        .restart_pulse(restart_pulse),
        .gcall_pulse  (gcall_pulse),
        .stop_pulse   (stop_pulse)
    );

    tgt_rx_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rxq (
        .clk  (clk),
        .rst_n(rst_n),
        .push (rx_push),
        .wdata(rx_wdata),
        .pop  (rx_pop),
        .rdata(rx_data),
        .valid(rx_valid),
        .full (rx_full),
        .count(rx_cnt)
    );
endmodule

// File: rtl/tgt_i2c_chk.sv
module tgt_i2c_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       enable,
    input logic                       gc_ignore,
    input logic                       scl_f,
    input logic                       rx_full,
    input logic                       tx_valid,
    input logic [$clog2(DEPTH+1)-1:0] rx_cnt,
    input logic                       scl_drive_low,
    input logic                       sda_drive_low,
    input logic                       restart_pulse,
    input logic                       gcall_pulse,
    input logic                       stop_pulse
);
    // R11
    sda_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && (sda_drive_low != $past(sda_drive_low))) |-> !$past(scl_f));

    // R1
    quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sda_drive_low && !scl_drive_low));

    // R6
    stretch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> ($past(rx_full) || !$past(tx_valid)));

    // R4
    fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= ($clog2(DEPTH+1))'(DEPTH));

    // R9
    restart_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pulse |=> !restart_pulse);

    // R9
    stop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({restart_pulse, gcall_pulse, stop_pulse}));

    // R3
    gcall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gcall_pulse |-> !$past(gc_ignore));
endmodule

bind i2c_tgt_hold tgt_i2c_chk #(.DEPTH(RX_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .gc_ignore    (gc_ignore),
    .scl_f        (scl_f),
    .rx_full      (rx_full),
    .tx_valid     (tx_valid),
    .rx_cnt       (rx_cnt),
    .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low),
    .restart_pulse(restart_pulse),
    .gcall_pulse  (gcall_pulse),
    .stop_pulse   (stop_pulse)
);

// File: tb/test_i2c_tgt_hold.sv
`timescale 1ns/1ps
module test_i2c_tgt_hold;
    localparam int Q = 24;
    localparam logic [6:0] OWN = 7'h3A;

    logic clk = 1'b0;
    logic rst_n, enable, tgt_sel, gc_ignore, nack_data;
    logic [6:0] own_addr;
    logic scl_m, sda_m, scl_bus, sda_bus;
    logic scl_drive_low, sda_drive_low, rx_valid, rx_pop, tx_valid, tx_take;
    logic [7:0] rx_data, tx_data;
    logic restart_pulse, gcall_pulse, stop_pulse;

    int checks = 0, errors = 0, cycles = 0;
    int n_restart = 0, n_gcall = 0, n_stop = 0, n_viol = 0;
    bit mon_en = 1'b1;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    logic [7:0] tx_q[$];

    always #2 clk = ~clk;

    assign scl_bus = scl_m & ~scl_drive_low;
    assign sda_bus = sda_m & ~sda_drive_low;

    i2c_tgt_hold i_i2c_tgt_hold (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tgt_sel(tgt_sel),
        .own_addr(own_addr), .gc_ignore(gc_ignore), .nack_data(nack_data),
        .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_take(tx_take),
        .restart_pulse(restart_pulse), .gcall_pulse(gcall_pulse),
        .stop_pulse(stop_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wait_high(); wt(Q);
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b1; wait_high(); wt(Q);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic m_bit(input bit b, output bit r, input bit glitch);
        sda_m = b; wt(Q);
        if (glitch) begin
            scl_m = 1'b1; wt(3); scl_m = 1'b0; wt(Q);
        end
        scl_m = 1'b1; wait_high(); wt(Q / 2);
        r = sda_bus; wt(Q / 2);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic m_wbyte(input logic [7:0] b, output bit ack, input int gl);
        bit r;
        for (int i = 7; i >= 0; i--) m_bit(b[i], r, i == gl);
        m_bit(1'b1, r, 1'b0);
        ack = !r;
    endtask

    task automatic m_rbyte(output logic [7:0] v, input bit last);
        bit r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r, 1'b0);
            v[i] = r;
        end
        m_bit(last, r, 1'b0);
    endtask

    task automatic addr(input logic [7:0] b, input bit exp_ack, input string req);
        bit a;
        m_wbyte(b, a, -1);
        chk(a == exp_ack, req, "address ack", a, exp_ack);
    endtask

    // driver side of the scoreboard
    task automatic send(input logic [7:0] b, input bit store, input bit exp_ack,
                        input string req);
        bit a;
        if (store) exp_q.push_back(b);
        m_wbyte(b, a, -1);
        chk(a == exp_ack, req, "data ack", a, exp_ack);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_pop) rx_pop = 1'b0;
            else if (rx_valid && mon_en) begin
                if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected byte", rx_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e, "R4", "byte order", rx_data, e);
                end
                rx_pop = 1'b1;
            end
        end
    end

    // transmit byte provider
    always @(negedge clk) begin
        if (tx_valid && tx_take) tx_valid = 1'b0;
        else if (!tx_valid && tx_q.size() != 0) begin
            tx_data  = tx_q.pop_front();
            tx_valid = 1'b1;
        end
    end

    logic sda_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            n_restart += int'(restart_pulse);
            n_gcall   += int'(gcall_pulse);
            n_stop    += int'(stop_pulse);
            if (enable && sda_drive_low != sda_prev && scl_bus) n_viol++;
        end
        sda_prev = sda_drive_low;
    end

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            chk(1'b0, "ALL", "watchdog expired", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int s0;
        rst_n = 1'b0; enable = 1'b0; tgt_sel = 1'b1; own_addr = OWN;
        gc_ignore = 1'b0; nack_data = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        rx_pop = 1'b0; tx_valid = 1'b0; tx_data = '0;
        wt(5);
        chk(!scl_drive_low && !sda_drive_low && !rx_valid, "R1", "reset outputs",
            {scl_drive_low, sda_drive_low, rx_valid}, 0);
        rst_n = 1'b1; wt(5);

        // R1: disabled block ignores its own address
        m_start(); addr({OWN, 1'b0}, 1'b0, "R1"); m_stop();
        enable = 1'b1; wt(20);

        // R2 R4: write three bytes
        s0 = n_stop;
        m_start(); addr({OWN, 1'b0}, 1'b1, "R2");
        send(8'h11, 1, 1, "R4"); send(8'hA5, 1, 1, "R4"); send(8'h7E, 1, 1, "R4");
        m_stop(); wt(100);
        chk(exp_q.size() == 0, "R4", "queue drained", exp_q.size(), 0);
        chk(n_stop == s0 + 1, "R9", "stop pulse", n_stop - s0, 1);

        // R2: foreign address, no stop pulse
        s0 = n_stop;
        m_start(); addr({7'h15, 1'b0}, 1'b0, "R2"); m_stop(); wt(20);
        chk(n_stop == s0, "R9", "stop when unaddressed", n_stop - s0, 0);

        // R3: broadcast accepted by default, refused when ignored
        m_start(); addr(8'h00, 1'b1, "R3");
        chk(n_gcall == 1, "R3", "gcall pulse", n_gcall, 1);
        send(8'h42, 1, 1, "R3"); m_stop();
        gc_ignore = 1'b1;
        m_start(); addr(8'h00, 1'b0, "R3"); m_stop();
        chk(n_gcall == 1, "R3", "no pulse when ignored", n_gcall, 1);
        gc_ignore = 1'b0;

        // R10: short SCL spike inside the address byte
        begin
            bit a;
            m_start(); m_wbyte({OWN, 1'b0}, a, 3);
            chk(a == 1'b1, "R10", "ack after spike", a, 1);
            send(8'h99, 1, 1, "R10"); m_stop();
        end

        // R5: refused data bytes
        nack_data = 1'b1;
        m_start(); addr({OWN, 1'b0}, 1'b1, "R5");
        send(8'h55, 0, 0, "R5"); m_stop(); wt(40);
        chk(!rx_valid, "R5", "nothing stored", rx_valid, 0);
        nack_data = 1'b0;

        // R6: full queue stretches the clock
        mon_en = 1'b0;
        m_start(); addr({OWN, 1'b0}, 1'b1, "R6");
        for (int i = 0; i < 16; i++) send(8'hD0 + 8'(i), 1, 1, "R6");
        fork
            send(8'hE7, 1, 1, "R6");
            begin
                wt(1200);
                chk(scl_drive_low == 1'b1, "R6", "clock held when full", scl_drive_low, 1);
                mon_en = 1'b1;
            end
        join
        m_stop(); wt(200);
        chk(exp_q.size() == 0, "R6", "all bytes delivered", exp_q.size(), 0);

        // R9 R7 R8: write, repeated start, read two bytes
        s0 = n_stop;
        m_start(); addr({OWN, 1'b0}, 1'b1, "R9");
        send(8'h31, 1, 1, "R9");
        tx_q.push_back(8'hC3); tx_q.push_back(8'h5A);
        m_start();
        chk(n_restart == 1, "R9", "restart pulse", n_restart, 1);
        addr({OWN, 1'b1}, 1'b1, "R7");
        m_rbyte(v, 1'b0); chk(v == 8'hC3, "R7", "read byte 0", v, 8'hC3);
        m_rbyte(v, 1'b1); chk(v == 8'h5A, "R7", "read byte 1", v, 8'h5A);
        begin
            bit r;
            m_bit(1'b1, r, 1'b0);
            chk(r == 1'b1, "R8", "released after nack", r, 1);
        end
        m_stop(); wt(20);
        chk(n_stop == s0 + 1, "R9", "stop after read", n_stop - s0, 1);

        // R7: read with no byte offered stretches the clock
        m_start(); addr({OWN, 1'b1}, 1'b1, "R7");
        fork
            m_rbyte(v, 1'b1);
            begin
                wt(400);
                chk(scl_drive_low == 1'b1, "R7", "clock held without data", scl_drive_low, 1);
                tx_q.push_back(8'h96);
            end
        join
        chk(v == 8'h96, "R7", "stretched read byte", v, 8'h96);
        m_stop();

        // R1: controller role captured while disabled
        enable = 1'b0; tgt_sel = 1'b0; wt(5); enable = 1'b1; tgt_sel = 1'b1; wt(5);
        m_start(); addr({OWN, 1'b0}, 1'b0, "R1"); m_stop();
        enable = 1'b0; wt(5); enable = 1'b1; wt(5);
        m_start(); addr({OWN, 1'b0}, 1'b1, "R1"); m_stop();

        wt(50);
        chk(n_viol == 0, "R11", "sda changed while scl high", n_viol, 0);
        chk(exp_q.size() == 0, "R4", "scoreboard empty", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule